// File: doc/BRIEF.md
# Prioritized Prefetch Request Queue

This block sits between a prefetch address generator and the memory side of a cache. Each cycle it may accept one candidate: an address, a secure-space flag, a signed priority and an optional program counter. The candidate is aligned down to a cache block. If an equal entry is already queued, the candidate is merged into it. If the target is already present in the cache or the miss queue, the candidate is discarded. Otherwise it is stored in a small queue that stays sorted by priority. Requests leave the queue in that order through a valid/ready port, and each one waits a configured number of cycles after it is stored before it may leave.

A demand access seen by the cache can squash every queued entry for the same block. When the generator is trained on virtual addresses, the block turns each candidate into a physical target. It takes the trigger access's physical address and adds the distance between the candidate and the trigger's virtual address. Duplicate filtering and squashing still compare the trained (virtual) addresses. Snooping and issue use the physical target.

Top module: `pfq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the queue is empty and `iss_valid` is low.
- R2: The candidate address and the demand address are aligned down to a multiple of `BLK_BYTES` (64 by default) before any comparison or insertion, so the low six address bits never distinguish entries.
- R3: `iss_valid` is high when the head entry has finished its delay. A cycle with `iss_valid` and `iss_ready` both high removes the head. While the port stalls with no candidate and no demand, the presented request does not change.
- R4: A demand access removes, at the next clock edge, every queued entry whose aligned address and secure flag both equal the demand's.
- R5: A candidate whose aligned address and secure flag match a queued entry inserts nothing. If its priority is strictly greater, that entry takes the new priority and moves behind all entries of equal or higher priority. Otherwise the queue is unchanged.
- R6: Entries leave in descending signed priority. A new entry is placed after every entry whose priority is greater than or equal to its own, so equal priorities leave in arrival order.
- R7: An entry stored at clock edge k can first be presented after edge k+`LATENCY`.
- R8: `snp_addr` and `snp_secure` present the candidate's target combinationally. A candidate that is not a duplicate is dropped when `snp_hit` is high in its cycle.
- R9: Inserting into a full queue first evicts the lowest-priority entry. Among entries tied at that priority, the one nearest the head (the oldest) goes. The queue never holds more than `DEPTH` entries.
- R10: With `VIRT_MODE` set, the target equals `trig_paddr + (aligned candidate - trig_vaddr)` modulo 2^32. Forward and backward offsets are handled, including offsets that cross address zero.
- R11: The issued request carries the entry's secure flag. With `TAG_PC` set, it also carries the candidate's PC, and `iss_pc_valid` follows `cand_pc_valid`.
- R12: Within one cycle the updates apply in this order: head pop, squash, duplicate filter, snoop drop, eviction, insertion. A candidate for a block squashed in the same cycle is therefore stored as a fresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_addr | input | 32 | Candidate address (trained space) |
| cand_secure | input | 1 | Candidate secure-space flag |
| cand_prio | input | 8 | Candidate priority, signed |
| cand_pc_valid | input | 1 | Candidate PC is meaningful |
| cand_pc | input | 32 | Candidate program counter |
| trig_vaddr | input | 32 | Virtual address of the triggering access |
| trig_paddr | input | 32 | Physical address of the triggering access |
| dem_valid | input | 1 | Demand access present this cycle |
| dem_addr | input | 32 | Demand address (trained space) |
| dem_secure | input | 1 | Demand secure-space flag |
| snp_addr | output | 32 | Target address for cache/miss-queue lookup |
| snp_secure | output | 1 | Secure flag for the lookup |
| snp_hit | input | 1 | Lookup found the target, same cycle |
| iss_valid | output | 1 | Head request available |
| iss_ready | input | 1 | Memory side accepts the head request |
| iss_addr | output | 32 | Issued target address |
| iss_secure | output | 1 | Issued secure flag |
| iss_pc_valid | output | 1 | Issued PC is meaningful |
| iss_pc | output | 32 | Issued program counter |

## Verification
The bound assertions watch properties that hold on every cycle: the empty state after reset, that occupancy never exceeds the depth, that a stalled port with no other traffic holds its request, that a demand with no candidate never grows the queue, and that a freshly filled queue waits out its delay. Issue order, merging with promotion, choice of eviction victim, squash matching, address translation and same-cycle ordering all depend on sequences of events. These can only be shown by the bench's directed scenarios and its random phase, compared cycle by cycle against a reference model.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int PFQ_AW = 32;
    localparam int PFQ_PW = 8;
    localparam int PFQ_CW = 8;

    typedef logic [PFQ_AW-1:0]        addr_t;
    typedef logic signed [PFQ_PW-1:0] prio_t;
    typedef logic [PFQ_CW-1:0]        dly_t;

    typedef struct packed {
        addr_t key;
        addr_t tgt;
        logic  sec;
        prio_t prio;
        logic  pcv;
        addr_t pc;
        dly_t  dly;
    } pf_entry_t;

    function automatic addr_t blk_align(addr_t a, int unsigned lg);
        return (a >> lg) << lg;
    endfunction

    function automatic pf_entry_t age_entry(pf_entry_t e);
        pf_entry_t r;
        r = e;
        if (e.dly != '0) r.dly = e.dly - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pfq_xlate.sv
module pfq_xlate
    import pfq_pkg::*;
#(
    parameter int BLK_LG    = 6,
    parameter bit VIRT_MODE = 1'b0
) (
    input  addr_t raw_addr,
    input  addr_t trig_vaddr,
    input  addr_t trig_paddr,
    output addr_t key,
    output addr_t tgt
);
    assign key = blk_align(raw_addr, BLK_LG);

    generate
        if (VIRT_MODE) begin : g_virt
            // modular add covers forward and backward distances alike
            assign tgt = trig_paddr + (key - trig_vaddr);
        end else begin : g_phys
            addr_t unused_v;
            assign unused_v = trig_vaddr ^ trig_paddr;
            assign tgt = key;
        end
    endgenerate
endmodule

// File: rtl/pfq_compact.sv
module pfq_compact
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNTW  = $clog2(DEPTH + 1),
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  pf_entry_t        din  [DEPTH],
    input  logic [DEPTH-1:0] keep,
    output pf_entry_t        dout [DEPTH],
    output logic [CNTW-1:0]  n
);
    // order-preserving removal of every slot whose keep bit is low
    always_comb begin
        for (int i = 0; i < DEPTH; i++) dout[i] = '0;
        n = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                dout[n[IDXW-1:0]] = din[i];
                n = n + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 64,
    parameter int LATENCY   = 4,
    parameter bit EN_SQUASH = 1'b1,
    parameter bit EN_FILTER = 1'b1,
    parameter bit EN_SNOOP  = 1'b1,
    parameter bit VIRT_MODE = 1'b0,
    parameter bit TAG_PC    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cand_valid,
    input  logic [31:0] cand_addr,
    input  logic        cand_secure,
    input  logic [7:0]  cand_prio,
    input  logic        cand_pc_valid,
    input  logic [31:0] cand_pc,
    input  logic [31:0] trig_vaddr,
    input  logic [31:0] trig_paddr,
    input  logic        dem_valid,
    input  logic [31:0] dem_addr,
    input  logic        dem_secure,
    output logic [31:0] snp_addr,
    output logic        snp_secure,
    input  logic        snp_hit,
    output logic        iss_valid,
    input  logic        iss_ready,
    output logic [31:0] iss_addr,
    output logic        iss_secure,
    output logic        iss_pc_valid,
    output logic [31:0] iss_pc
);
    localparam int BLK_LG = $clog2(BLK_BYTES);
    localparam int CNTW   = $clog2(DEPTH + 1);
    localparam int IDXW   = $clog2(DEPTH);

    pf_entry_t       q     [DEPTH];
    pf_entry_t       aged  [DEPTH];
    pf_entry_t       sa    [DEPTH];
    pf_entry_t       sb    [DEPTH];
    pf_entry_t       nxt   [DEPTH];
    logic [CNTW-1:0] count, cnt_a, cnt_b, nxt_cnt, pos;
    logic [DEPTH-1:0] keep_a, keep_b, hit_vec;
    logic            pop, hit_any, ins_en, rm_en;
    logic [IDXW-1:0] hit_idx, victim, rm_idx;
    addr_t           cand_key, cand_tgt, dem_key, dem_tgt_unused;
    pf_entry_t       ins_ent;

    pfq_xlate #(.BLK_LG(BLK_LG), .VIRT_MODE(VIRT_MODE)) u_cand_xl (
        .raw_addr(cand_addr), .trig_vaddr(trig_vaddr), .trig_paddr(trig_paddr),
        .key(cand_key), .tgt(cand_tgt));

    pfq_xlate #(.BLK_LG(BLK_LG), .VIRT_MODE(1'b0)) u_dem_xl (
        .raw_addr(dem_addr), .trig_vaddr(trig_vaddr), .trig_paddr(trig_paddr),
        .key(dem_key), .tgt(dem_tgt_unused));

    assign snp_addr   = cand_tgt;
    assign snp_secure = cand_secure;

    // issue side
    assign iss_valid    = (count != '0) && (q[0].dly == '0);
    assign iss_addr     = q[0].tgt;
    assign iss_secure   = q[0].sec;
    assign iss_pc_valid = q[0].pcv;
    assign iss_pc       = q[0].pc;
    assign pop          = iss_valid && iss_ready;

    // stage A: age, pop head, squash
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            aged[i]   = age_entry(q[i]);
            keep_a[i] = (CNTW'(i) < count) && !(i == 0 && pop) &&
                        !(EN_SQUASH && dem_valid && q[i].key == dem_key &&
                          q[i].sec == dem_secure);
        end
    end

    pfq_compact #(.DEPTH(DEPTH)) u_cmp_a (
        .din(aged), .keep(keep_a), .dout(sa), .n(cnt_a));

    // duplicate search and eviction victim on stage A
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        victim  = '0;
        for (int i = 0; i < DEPTH; i++)
            hit_vec[i] = EN_FILTER && cand_valid && (CNTW'(i) < cnt_a) &&
                         sa[i].key == cand_key && sa[i].sec == cand_secure;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDXW'(i);
            end
            if (CNTW'(i) < cnt_a && sa[i].prio == sa[DEPTH-1].prio) victim = IDXW'(i);
        end
    end

    // decision: promote, drop, or insert (with optional eviction)
    always_comb begin
        ins_en       = 1'b0;
        rm_en        = 1'b0;
        rm_idx       = '0;
        ins_ent.key  = cand_key;
        ins_ent.tgt  = cand_tgt;
        ins_ent.sec  = cand_secure;
        ins_ent.prio = cand_prio;
        ins_ent.pcv  = TAG_PC && cand_pc_valid;
        ins_ent.pc   = cand_pc;
        ins_ent.dly  = dly_t'(LATENCY);
        if (cand_valid) begin
            if (hit_any) begin
                if ($signed(cand_prio) > $signed(sa[hit_idx].prio)) begin
                    rm_en        = 1'b1;
                    rm_idx       = hit_idx;
                    ins_en       = 1'b1;
                    ins_ent      = sa[hit_idx];
                    ins_ent.prio = cand_prio;
                end
            end else if (!(EN_SNOOP && snp_hit)) begin
                ins_en = 1'b1;
                if (cnt_a == CNTW'(DEPTH)) begin
                    rm_en  = 1'b1;
                    rm_idx = victim;
                end
            end
        end
        for (int i = 0; i < DEPTH; i++)
            keep_b[i] = (CNTW'(i) < cnt_a) && !(rm_en && IDXW'(i) == rm_idx);
    end

    pfq_compact #(.DEPTH(DEPTH)) u_cmp_b (
        .din(sa), .keep(keep_b), .dout(sb), .n(cnt_b));

    // sorted insertion behind all entries of equal or higher priority
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CNTW'(i) < cnt_b && $signed(sb[i].prio) >= $signed(ins_ent.prio))
                pos = pos + 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ins_en || CNTW'(i) < pos) nxt[i] = sb[i];
            else if (CNTW'(i) == pos)      nxt[i] = ins_ent;
            else                           nxt[i] = sb[(i == 0) ? 0 : i - 1];
        end
        nxt_cnt = cnt_b + CNTW'(ins_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= nxt_cnt;
            for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int DEPTH   = 8,
    parameter int LATENCY = 4,
    parameter int CNTW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            cand_valid,
    input logic            dem_valid,
    input logic            iss_valid,
    input logic            iss_ready,
    input logic [31:0]     iss_addr,
    input logic [CNTW-1:0] cnt
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !iss_valid);

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNTW'(DEPTH));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !cand_valid && !dem_valid)
        |=> iss_valid && $stable(iss_addr));

    assert_fresh_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (LATENCY > 0 && cnt != '0 && $past(cnt) == '0) |-> !iss_valid);

    assert_demand_no_grow_R4: assert property (@(posedge clk) disable iff (rst)
        (dem_valid && !cand_valid) |=> cnt <= $past(cnt));
endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_pfq_checker (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .dem_valid(dem_valid),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
    .cnt(count));

// File: tb/pfq_top_bench.sv
`timescale 1ns/1ps
module pfq_top_bench;
    localparam int DEPTH = 4;
    localparam int LAT   = 3;
    localparam int BLK   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        cand_valid = 0, cand_secure = 0, cand_pc_valid = 0;
    logic [31:0] cand_addr = 0, cand_pc = 0, trig_vaddr = 0, trig_paddr = 0;
    logic signed [7:0] cand_prio = 0;
    logic        dem_valid = 0, dem_secure = 0, snp_hit = 0, iss_ready = 0;
    logic [31:0] dem_addr = 0;
    logic [31:0] snp_addr, iss_addr, iss_pc;
    logic        snp_secure, iss_valid, iss_secure, iss_pc_valid;

    pfq_top #(.DEPTH(DEPTH), .BLK_BYTES(BLK), .LATENCY(LAT), .VIRT_MODE(1'b1),
              .TAG_PC(1'b1)) u_pfq_top (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_addr(cand_addr),
        .cand_secure(cand_secure), .cand_prio(cand_prio),
        .cand_pc_valid(cand_pc_valid), .cand_pc(cand_pc),
        .trig_vaddr(trig_vaddr), .trig_paddr(trig_paddr),
        .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_secure(dem_secure),
        .snp_addr(snp_addr), .snp_secure(snp_secure), .snp_hit(snp_hit),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
        .iss_secure(iss_secure), .iss_pc_valid(iss_pc_valid), .iss_pc(iss_pc));

    always #2.5 clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    string req = "R1";
    bit    rdy_g = 1;

    // reference model: parallel queues, index 0 is the head
    logic [31:0] mk[$], mt[$], mpc[$];
    bit          ms[$], mpv[$];
    int          mp[$], mw[$];

    function automatic logic [31:0] al(logic [31:0] a);
        return a & ~32'(BLK - 1);
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mdel(int i);
        mk.delete(i); mt.delete(i); mpc.delete(i); ms.delete(i);
        mpv.delete(i); mp.delete(i); mw.delete(i);
    endtask

    task automatic mins(int p, logic [31:0] k, logic [31:0] t, bit s, int pr,
                        bit pv, logic [31:0] pc, int w);
        mk.insert(p, k); mt.insert(p, t); ms.insert(p, s); mp.insert(p, pr);
        mpv.insert(p, pv); mpc.insert(p, pc); mw.insert(p, w);
    endtask

    function automatic int pos_for(int pr);
        int n = 0;
        foreach (mp[i]) if (mp[i] >= pr) n++;
        return n;
    endfunction

    task automatic compare_outputs();
        bit ev = (mk.size() > 0) && (mw[0] == 0);
        chk("iss_valid", 32'(iss_valid), 32'(ev));
        if (ev) begin
            chk("iss_addr", iss_addr, mt[0]);
            chk("iss_secure", 32'(iss_secure), 32'(ms[0]));
            chk("iss_pc_valid", 32'(iss_pc_valid), 32'(mpv[0]));
            if (mpv[0]) chk("iss_pc", iss_pc, mpc[0]);
        end
    endtask

    task automatic model_step();
        bit hv = (mk.size() > 0) && (mw[0] == 0);
        logic [31:0] k, t;
        int hit = -1;
        foreach (mw[i]) if (mw[i] > 0) mw[i]--;
        if (hv && iss_ready) mdel(0);
        if (dem_valid)
            for (int i = mk.size() - 1; i >= 0; i--)
                if (mk[i] == al(dem_addr) && ms[i] == dem_secure) mdel(i);
        if (cand_valid) begin
            k = al(cand_addr);
            t = trig_paddr + (k - trig_vaddr);
            foreach (mk[i]) if (hit < 0 && mk[i] == k && ms[i] == cand_secure) hit = i;
            if (hit >= 0) begin
                if (int'(cand_prio) > mp[hit]) begin
                    logic [31:0] sk = mk[hit], st = mt[hit], spc = mpc[hit];
                    bit ss = ms[hit], spv = mpv[hit];
                    int sw = mw[hit];
                    mdel(hit);
                    mins(pos_for(int'(cand_prio)), sk, st, ss, int'(cand_prio), spv, spc, sw);
                end
            end else if (!snp_hit) begin
                if (mk.size() == DEPTH) begin
                    int lo = mp[mp.size() - 1];
                    int j = -1;
                    foreach (mp[i]) if (j < 0 && mp[i] == lo) j = i;
                    mdel(j);
                end
                mins(pos_for(int'(cand_prio)), k, t, cand_secure, int'(cand_prio),
                     cand_pc_valid, cand_pc, LAT);
            end
        end
    endtask

    // one cycle: drive at the falling edge, check lookup, predict, check after edge
    task automatic cyc(bit cv, logic [31:0] ca, bit cs, int cp, bit cpv,
                       logic [31:0] cpc, bit dv, logic [31:0] da, bit ds, bit sh);
        cand_valid = cv; cand_addr = ca; cand_secure = cs; cand_prio = 8'(cp);
        cand_pc_valid = cpv; cand_pc = cpc; dem_valid = dv; dem_addr = da;
        dem_secure = ds; snp_hit = sh; iss_ready = rdy_g;
        #0.5;
        if (cv) begin
            chk("snp_addr", snp_addr, trig_paddr + (al(ca) - trig_vaddr));
            chk("snp_secure", 32'(snp_secure), 32'(cs));
        end
        model_step();
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic cand(logic [31:0] a, int p);
        cyc(1, a, 0, p, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        compare_outputs();
        chk("iss_valid in reset", 32'(iss_valid), 0);
        rst = 1'b0;
        idle(1);

        // R2 and R7: unaligned candidate, wait out the delay
        req = "R2"; rdy_g = 1;
        cand(32'h0000_1234, 0);
        req = "R7";
        idle(5);

        // R6: priority order, ties in arrival order
        req = "R6"; rdy_g = 0;
        cand(32'h2000, 1); cand(32'h2040, 3); cand(32'h2080, 1); cand(32'h20C0, 2);
        idle(4); rdy_g = 1; idle(6);

        // R5: duplicate promotes, lower duplicate ignored
        req = "R5"; rdy_g = 0;
        cand(32'h3000, 1); cand(32'h3040, 2); cand(32'h3010, 5); cand(32'h3050, 0);
        idle(4); rdy_g = 1; idle(5);

        // R8: snoop hit drops candidate
        req = "R8"; rdy_g = 1;
        cyc(1, 32'h4000, 0, 0, 0, 0, 0, 0, 0, 1);
        cand(32'h4040, 0);
        idle(5);

        // R9: eviction of the oldest lowest-priority entry
        req = "R9"; rdy_g = 0;
        cand(32'h5000, 2); cand(32'h5040, 1); cand(32'h5080, 1); cand(32'h50C0, 3);
        cand(32'h5100, 2); cand(32'h5140, 0); cand(32'h5180, 5);
        idle(3); rdy_g = 1; idle(6);

        // R4: squash by block and secure flag; R12: squash precedes insertion
        req = "R4"; rdy_g = 0;
        cand(32'h6000, 1); cand(32'h6040, 1);
        cyc(1, 32'h6000, 1, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h6008, 0, 0);
        req = "R12";
        cyc(1, 32'h6040, 0, 2, 0, 0, 1, 32'h6040, 0, 0);
        idle(1); rdy_g = 1; idle(6);

        // R10: virtual to physical, forward, backward, across zero
        req = "R10"; rdy_g = 1;
        trig_vaddr = 32'h0001_0000; trig_paddr = 32'h0008_0000;
        cand(32'h0001_0400, 0); cand(32'h0000_F000, 0);
        trig_vaddr = 32'hFFFF_F000; trig_paddr = 32'h0000_1000;
        cand(32'h0000_0000, 0);
        idle(6);
        trig_vaddr = 0; trig_paddr = 0;

        // R11: PC tag and secure flag carried to issue
        req = "R11"; rdy_g = 1;
        cyc(1, 32'h7000, 1, 0, 1, 32'hCAFE_0010, 0, 0, 0, 0);
        cyc(1, 32'h7040, 0, 0, 0, 32'hDEAD_0000, 0, 0, 0, 0);
        idle(6);

        // R3: mixed traffic with random back-pressure
        req = "R3";
        for (int i = 0; i < 400; i++) begin
            rdy_g = ($urandom_range(0, 2) != 0);
            cyc($urandom_range(0, 2) != 0,
                32'h8000 + 32'($urandom_range(0, 7) * 64 + $urandom_range(0, 63)),
                $urandom_range(0, 4) == 0, $urandom_range(0, 4) - 2,
                $urandom_range(0, 1), 32'($urandom),
                $urandom_range(0, 7) == 0, 32'h8000 + 32'($urandom_range(0, 7) * 64),
                1'b0, $urandom_range(0, 7) == 0);
        end
        rdy_g = 1; idle(10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule